// File: doc/BRIEF.md
# Dual-Stream Frame Alignment Unit

This unit sits in front of a video compositor. It takes a background pixel stream and an overlay pixel stream and brings them to a common start of frame. Each stream arrives on its own valid/ready interface. Every background beat carries a 24-bit pixel, a vertical sync flag and a horizontal sync flag. Every overlay beat carries the same fields plus an 8-bit alpha value. The unit does no pixel arithmetic. It only gates the two input handshakes, pairs pixels, and reports when the streams are locked together.

After reset, each stream hunts for the beat that carries its vertical sync. Beats without that flag are taken and thrown away. The sync beat is captured and held, and that stream then stalls until the other stream has captured its own sync beat. From that moment the unit is locked. The two held sync beats leave together as the first output pair. After that, each background beat is released only alongside one overlay beat, so the background stream sets the pace of the pair. The lock stays in place until the next reset, and each reset starts the search again.

Each stream has exactly one beat of storage. The reset input is asynchronous and active low. Its release is synchronised inside the unit over a parameterised number of clock edges.

Top module: `dual_frame_align`

## Requirements
- R1: A beat moves on a rising edge only when its valid and ready are both high. While out_valid is high and out_ready is low, out_valid stays high and every output field keeps its value.
- R2: While not locked, a stream whose storage is empty holds ready high. Any beat it receives with the vertical sync flag low is discarded and is never presented at the output.
- R3: While not locked, a stream that has captured a beat with its vertical sync flag high holds ready low. It keeps that beat unchanged until the other stream also captures its sync beat.
- R4: locked goes high in the first cycle in which both streams hold a captured beat. It then stays high until reset.
- R5: The first pair presented after lock consists of the two captured sync beats: background and overlay, each with its vertical sync flag high.
- R6: Once locked, every accepted beat of either stream is forwarded in arrival order, and none is dropped. Each stream stores at most one beat. A stream's ready is high when its storage is empty or when the stored pair leaves in the same cycle.
- R7: The horizontal sync flag, the vertical sync flag and the overlay alpha travel with their pixel unchanged.
- R8: out_valid is high exactly when the unit is locked and both streams hold a beat.
- R9: Pulling rst_n low at once forces both readies, out_valid and locked low. After release, both streams search for their next vertical sync again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bg_valid | input | 1 | Background beat valid |
| bg_ready | output | 1 | Background beat accepted |
| bg_data | input | PIX_W | Background pixel |
| bg_vs | input | 1 | Background first pixel of frame |
| bg_hs | input | 1 | Background first pixel of line |
| ov_valid | input | 1 | Overlay beat valid |
| ov_ready | output | 1 | Overlay beat accepted |
| ov_data | input | PIX_W | Overlay pixel |
| ov_alpha | input | ALPHA_W | Overlay transparency |
| ov_vs | input | 1 | Overlay first pixel of frame |
| ov_hs | input | 1 | Overlay first pixel of line |
| out_valid | output | 1 | Aligned pair available |
| out_ready | input | 1 | Downstream takes the pair |
| out_bg_data | output | PIX_W | Paired background pixel |
| out_bg_vs | output | 1 | Paired background frame flag |
| out_bg_hs | output | 1 | Paired background line flag |
| out_ov_data | output | PIX_W | Paired overlay pixel |
| out_ov_alpha | output | ALPHA_W | Paired overlay alpha |
| out_ov_vs | output | 1 | Paired overlay frame flag |
| out_ov_hs | output | 1 | Paired overlay line flag |
| locked | output | 1 | Streams aligned since last reset |

## Verification
The bench builds the unit with its default parameters: 24-bit pixels, 8-bit alpha and a two-stage reset release. Frame sizes are kept small (15 background beats, 6 overlay beats) so that many frame starts, and so both lock orders, occur within a short run. In one phase the overlay input is starved so the background stream reaches its sync first. In another the background is starved so the overlay gets there first. Resets are also applied in the middle of a locked run, with the generators stopped mid-frame, which forces a fresh search from a frame position other than zero.

// File: rtl/fa_pkg.sv
package fa_pkg;
  typedef enum logic {
    SLOT_EMPTY = 1'b0,
    SLOT_HELD  = 1'b1
  } slot_state_e;

  localparam int FA_DEF_PIX_W   = 24;
  localparam int FA_DEF_ALPHA_W = 8;
  localparam int FA_SYNC_FLAGS  = 2;
endpackage

// File: rtl/fa_reset_sync.sv
module fa_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  generate
    if (STAGES <= 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n_async) begin
        if (!rst_n_async) stage_q <= 1'b0;
        else              stage_q <= 1'b1;
      end
      assign rst_n_sync = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n_async) begin
        if (!rst_n_async) chain_q <= '0;
        else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
      assign rst_n_sync = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/fa_stream_slot.sv
module fa_stream_slot
  import fa_pkg::*;
#(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_vs,
  input  logic [W-1:0] in_payload,
  input  logic         locked,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] held_payload
);
  slot_state_e  state_q, state_d;
  logic         accept;
  logic         capture;
  logic [W-1:0] payload_q;

  // next-state
  always_comb begin
    in_ready = rst_n & ((state_q == SLOT_EMPTY) | take);
    accept   = in_valid & in_ready;
    capture  = accept & (locked | in_vs);
    state_d  = state_q;
    if (capture)   state_d = SLOT_HELD;
    else if (take) state_d = SLOT_EMPTY;
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLOT_EMPTY;
    else        state_q <= state_d;
  end

  // payload register, explicit enable, no reset
  always_ff @(posedge clk) begin
    if (capture) payload_q <= in_payload;
  end

  assign full         = (state_q == SLOT_HELD);
  assign held_payload = payload_q;

  // R2: an unsynced beat taken before lock leaves the slot empty
  assert_drop_unsynced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && in_valid && in_ready && !in_vs && !full) |=> !full);

  // R3: a held beat not taken stays held and unchanged
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(held_payload)));
endmodule

// File: rtl/fa_lock_tracker.sv
module fa_lock_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic bg_full,
  input  logic ov_full,
  input  logic out_ready,
  output logic locked,
  output logic out_valid,
  output logic take
);
  logic lock_q, lock_d;
  logic both_held;

  always_comb begin
    both_held = bg_full & ov_full;
    lock_d    = lock_q | both_held;
    locked    = lock_d;
    out_valid = lock_d & both_held;
    take      = out_valid & out_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  // R4: lock is sticky until reset
  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
endmodule

// File: rtl/dual_frame_align.sv
module dual_frame_align
  import fa_pkg::*;
#(
  parameter int PIX_W       = FA_DEF_PIX_W,
  parameter int ALPHA_W     = FA_DEF_ALPHA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bg_valid,
  output logic               bg_ready,
  input  logic [PIX_W-1:0]   bg_data,
  input  logic               bg_vs,
  input  logic               bg_hs,
  input  logic               ov_valid,
  output logic               ov_ready,
  input  logic [PIX_W-1:0]   ov_data,
  input  logic [ALPHA_W-1:0] ov_alpha,
  input  logic               ov_vs,
  input  logic               ov_hs,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [PIX_W-1:0]   out_bg_data,
  output logic               out_bg_vs,
  output logic               out_bg_hs,
  output logic [PIX_W-1:0]   out_ov_data,
  output logic [ALPHA_W-1:0] out_ov_alpha,
  output logic               out_ov_vs,
  output logic               out_ov_hs,
  output logic               locked
);
  localparam int BG_W = PIX_W + FA_SYNC_FLAGS;
  localparam int OV_W = PIX_W + ALPHA_W + FA_SYNC_FLAGS;

  logic            srst_n;
  logic            bg_full, ov_full;
  logic            take;
  logic [BG_W-1:0] bg_held;
  logic [OV_W-1:0] ov_held;

  fa_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (srst_n)
  );

  fa_stream_slot #(.W(BG_W)) u_bg_slot (
    .clk          (clk),
    .rst_n        (srst_n),
    .in_valid     (bg_valid),
    .in_ready     (bg_ready),
    .in_vs        (bg_vs),
    .in_payload   ({bg_vs, bg_hs, bg_data}),
    .locked       (locked),
    .take         (take),
    .full         (bg_full),
    .held_payload (bg_held)
  );

  fa_stream_slot #(.W(OV_W)) u_ov_slot (
    .clk          (clk),
    .rst_n        (srst_n),
    .in_valid     (ov_valid),
    .in_ready     (ov_ready),
    .in_vs        (ov_vs),
    .in_payload   ({ov_vs, ov_hs, ov_alpha, ov_data}),
    .locked       (locked),
    .take         (take),
    .full         (ov_full),
    .held_payload (ov_held)
  );

  fa_lock_tracker u_lock (
    .clk       (clk),
    .rst_n     (srst_n),
    .bg_full   (bg_full),
    .ov_full   (ov_full),
    .out_ready (out_ready),
    .locked    (locked),
    .out_valid (out_valid),
    .take      (take)
  );

  assign {out_bg_vs, out_bg_hs, out_bg_data}               = bg_held;
  assign {out_ov_vs, out_ov_hs, out_ov_alpha, out_ov_data} = ov_held;

  // R1: a stalled pair stays presented and unchanged
  assert_out_hold_R1: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(bg_held) && $stable(ov_held)));

  // R5: the pair presented at lock is the two frame-start beats
  assert_first_pair_R5: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(locked) |-> (out_valid && out_bg_vs && out_ov_vs));

  // R3: before lock a stream holding its frame start is stalled
  assert_bg_blocked_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (!locked && bg_full) |-> !bg_ready);
  assert_ov_blocked_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (!locked && ov_full) |-> !ov_ready);
endmodule

// File: tb/dual_frame_align_tb_top.sv
module dual_frame_align_tb_top;
  localparam int PW = 24;
  localparam int AW = 8;
  localparam int BG_LEN = 15, BG_LINE = 5;
  localparam int OV_LEN = 6,  OV_LINE = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic bg_valid, bg_ready, bg_vs, bg_hs;
  logic [PW-1:0] bg_data;
  logic ov_valid, ov_ready, ov_vs, ov_hs;
  logic [PW-1:0] ov_data;
  logic [AW-1:0] ov_alpha;
  logic out_valid, out_ready;
  logic [PW-1:0] out_bg_data, out_ov_data;
  logic [AW-1:0] out_ov_alpha;
  logic out_bg_vs, out_bg_hs, out_ov_vs, out_ov_hs, locked;

  always #2 clk = ~clk;

  dual_frame_align dut_i (
    .clk(clk), .rst_n(rst_n),
    .bg_valid(bg_valid), .bg_ready(bg_ready), .bg_data(bg_data), .bg_vs(bg_vs), .bg_hs(bg_hs),
    .ov_valid(ov_valid), .ov_ready(ov_ready), .ov_data(ov_data), .ov_alpha(ov_alpha),
    .ov_vs(ov_vs), .ov_hs(ov_hs),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_bg_data(out_bg_data), .out_bg_vs(out_bg_vs), .out_bg_hs(out_bg_hs),
    .out_ov_data(out_ov_data), .out_ov_alpha(out_ov_alpha), .out_ov_vs(out_ov_vs),
    .out_ov_hs(out_ov_hs), .locked(locked)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [PW+1:0]    bq[$];
  logic [PW+AW+1:0] oq[$];
  bit lock_m;
  bit first_pending;
  bit prev_stall;
  int b_idx = 0, b_frm = 0, o_idx = 0, o_frm = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive_gen(bit bv, bit ov);
    bg_valid = bv;
    bg_data  = {4'hB, 8'(b_frm), 12'(b_idx)};
    bg_vs    = (b_idx == 0);
    bg_hs    = (b_idx % BG_LINE == 0);
    ov_valid = ov;
    ov_data  = {4'hA, 8'(o_frm), 12'(o_idx)};
    ov_alpha = 8'(o_idx * 7 + o_frm);
    ov_vs    = (o_idx == 0);
    ov_hs    = (o_idx % OV_LINE == 0);
  endtask

  task automatic step(bit hold_bg, bit hold_ov);
    bit fb, fo, lk, ev, fire, rb, ro, bfire, ofire;
    string rq;
    @(negedge clk);
    drive_gen(!hold_bg && ($urandom % 4 != 0), !hold_ov && ($urandom % 4 != 0));
    out_ready = ($urandom % 4 != 0);
    #1;
    fb = (bq.size() != 0);
    fo = (oq.size() != 0);
    lk = lock_m || (fb && fo);
    ev = lk && fb && fo;
    fire = ev && out_ready;
    rb = !fb || fire;
    ro = !fo || fire;
    check("R4 locked", 64'(locked), 64'(lk));
    check("R8 out_valid", 64'(out_valid), 64'(ev));
    rq = !lk ? (fb ? "R3 bg_ready" : "R2 bg_ready") : "R6 bg_ready";
    check(rq, 64'(bg_ready), 64'(rb));
    rq = !lk ? (fo ? "R3 ov_ready" : "R2 ov_ready") : "R6 ov_ready";
    check(rq, 64'(ov_ready), 64'(ro));
    if (ev) begin
      rq = first_pending ? "R5 pair" : (prev_stall ? "R1 stalled pair" : "R6 pair");
      check(rq, 64'({out_bg_data, out_ov_data}), 64'({bq[0][PW-1:0], oq[0][PW-1:0]}));
      check("R7 flags", 64'({out_bg_vs, out_bg_hs, out_ov_vs, out_ov_hs, out_ov_alpha}),
            64'({bq[0][PW+1], bq[0][PW], oq[0][PW+AW+1], oq[0][PW+AW], oq[0][PW+AW-1:PW]}));
    end
    prev_stall = ev && !out_ready;
    bfire = bg_valid && rb;
    ofire = ov_valid && ro;
    @(posedge clk);
    if (fire) begin
      void'(bq.pop_front());
      void'(oq.pop_front());
      first_pending = 0;
    end
    if (!lock_m && lk) first_pending = 1;
    if (bfire && (lk || bg_vs)) bq.push_back({bg_vs, bg_hs, bg_data});
    if (ofire && (lk || ov_vs)) oq.push_back({ov_vs, ov_hs, ov_alpha, ov_data});
    if (fire) first_pending = 0;
    lock_m = lk;
    if (bfire) begin b_idx++; if (b_idx == BG_LEN) begin b_idx = 0; b_frm++; end end
    if (ofire) begin o_idx++; if (o_idx == OV_LEN) begin o_idx = 0; o_frm++; end end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bg_valid = 1'b0;
    ov_valid = 1'b0;
    out_ready = 1'b0;
    #1;
    check("R9 bg_ready in reset", 64'(bg_ready), 64'(0));
    check("R9 ov_ready in reset", 64'(ov_ready), 64'(0));
    check("R9 locked in reset", 64'(locked), 64'(0));
    check("R9 out_valid in reset", 64'(out_valid), 64'(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bq.delete();
    oq.delete();
    lock_m = 0;
    first_pending = 0;
    prev_stall = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    drive_gen(0, 0);
    out_ready = 1'b0;
    do_reset();
    // background reaches frame start first
    for (int i = 0; i < 30; i++) step(0, 1);
    for (int i = 0; i < 400; i++) step(0, 0);
    // overlay reaches frame start first, reset taken mid-frame
    do_reset();
    for (int i = 0; i < 30; i++) step(1, 0);
    for (int i = 0; i < 400; i++) step(0, 0);
    do_reset();
    for (int i = 0; i < 500; i++) step(0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule